// File: doc/BRIEF.md
# Multi-Thread Reorder Buffer with Bounded Squash Walk

This block tracks in-flight operations in program order for several hardware threads at once. Each thread owns a private circular queue of entries. Every entry carries a sequence number, a flag that says the operation may commit, and a flag that says it was squashed. The dispatch stage appends entries at a thread's tail over a valid/ready stream. The execution side marks an entry as able to commit by naming its slot. The commit stage pulls entries off a thread's head over a second valid/ready stream, but only once that head may commit.

A squash request names a thread and a sequence number. It starts a walk over that thread's entries. The walk begins at the youngest entry and moves toward the oldest, handling at most `SQ_WIDTH` entries per cycle. Every entry it visits whose sequence number is above the squash number is flagged squashed and made able to commit. The walk ends at the first entry at or below the squash number, or after it handles the oldest entry. Squashed entries keep their slots. They leave through the normal retire stream with their squashed flag visible, so the commit stage can discard them.

Back-pressure rules:
- Dispatch is refused (`disp_ready` low) when any of these holds for the selected thread:
  - the thread holds `DEPTH` entries;
  - the whole buffer holds `CAP` entries;
  - a walk is running on that thread;
  - a squash request for that thread is present in the same cycle.
- Retire is refused (`ret_ready` low) unless the selected thread's head may commit and no walk or squash request is active on that thread.
- A transfer takes place on a clock edge where valid and ready are both high. Ready never depends on valid.

Top module: `rob_mt`

## Requirements
- R1: After reset every thread is empty. `head_ready` and `can_commit` are 0, every `sq_done` bit is 1, and dispatch to any thread is ready.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both high. The entry is appended at the thread's tail, and `disp_slot` gives its slot index in that same cycle. `disp_ready` is low when the thread already holds `DEPTH` entries or when the total across threads equals `CAP`.
- R3: Retire on thread t returns that thread's oldest entry, with `ret_seq` and `ret_squashed`, in dispatch order. `ret_ready` is low while that head may not commit.
- R4: `head_ready[t]` is 1 exactly when thread t holds at least one entry and its oldest entry has been marked able to commit. Marking happens through `cmpl_valid` with `cmpl_tid`/`cmpl_slot`, or through a squash walk.
- R5: `can_commit` is 1 exactly when some thread with its `thr_active` bit set has `head_ready` high.
- R6: A squash request on a thread that holds no entries is ignored, and that thread's `sq_done` stays 1.
- R7: After a walk completes, every entry of the thread with sequence number greater than the squash number has its squashed flag and commit flag set. Every other entry is unchanged.
- R8: `sq_done[t]` goes low on the edge that accepts the squash. It stays low for max(1, ceil(m / `SQ_WIDTH`)) cycles, where m is the number of the thread's entries above the squash number.
- R9: The walk frees no entry. Squashed entries stay in the thread's queue and leave through retire, with `ret_squashed` = 1.
- R10: A dispatch and a retire on the same thread in the same cycle are both accepted. The occupancy stays the same, and both entries keep their order.
- R11: A squash request for a thread whose walk is still running is ignored. The running walk finishes with its original squash number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted for `disp_tid` |
| disp_tid | input | TW | Dispatch thread |
| disp_seq | input | SEQ_W | Sequence number of the new entry |
| disp_slot | output | PW | Slot the new entry occupies |
| cmpl_valid | input | 1 | Mark an entry able to commit |
| cmpl_tid | input | TW | Thread of the completing entry |
| cmpl_slot | input | PW | Slot of the completing entry |
| ret_valid | input | 1 | Retire request |
| ret_ready | output | 1 | Head of `ret_tid` can be retired |
| ret_tid | input | TW | Retire thread |
| ret_seq | output | SEQ_W | Sequence number of that head |
| ret_squashed | output | 1 | That head was squashed |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TW | Squash thread |
| sq_seq | input | SEQ_W | Squash boundary sequence number |
| thr_active | input | NTHR | Threads considered for `can_commit` |
| head_ready | output | NTHR | Per-thread head can commit |
| can_commit | output | 1 | Some active thread can commit |
| sq_done | output | NTHR | Per-thread squash walk idle |

## Verification
Dispatch and retire can land on one thread in the same edge. The bench sets up a thread whose head may commit and that has spare room. It then raises both streams in one cycle and requires both ready signals high. The retire stream must return the old head first, and the newly dispatched entry must follow later in order. A squash request that arrives while a walk is running on the same thread is a second collision. It is judged by retiring every entry afterwards and requiring all of them to carry the squashed flag of the first, lower boundary.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_st_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/rob_thread_q.sv
`timescale 1ns/1ps
module rob_thread_q
  import rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int SQ_WIDTH = 2,
  localparam int PW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  output logic [PW-1:0]    tail_slot,
  input  logic             pop,
  input  logic             mark,
  input  logic [PW-1:0]    mark_slot,
  input  logic             sq_req,
  input  logic [SEQ_W-1:0] sq_num,
  output logic             head_rdy,
  output logic [SEQ_W-1:0] head_seq,
  output logic             head_sqd,
  output logic [CW-1:0]    count,
  output logic             walk_busy
);

  localparam int MAXW = ceil_div(DEPTH, SQ_WIDTH);
  localparam int WCW  = $clog2(MAXW + 1);

  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [DEPTH-1:0] rdy_q, sqd_q;
  logic [PW-1:0]    hd_q, tl_q, wp_q;
  logic [CW-1:0]    cnt_q;
  logic [SEQ_W-1:0] sqn_q;
  walk_st_e         st_q;

  logic             start;
  logic [PW-1:0]    w_cur;
  logic             w_fin;
  logic [DEPTH-1:0] w_hit;

  assign start = sq_req && (st_q == WK_IDLE) && (cnt_q != '0);

  // Walker: up to SQ_WIDTH entries per cycle, youngest toward head.
  always_comb begin
    w_cur = wp_q;
    w_fin = 1'b0;
    w_hit = '0;
    for (int k = 0; k < SQ_WIDTH; k++) begin
      if (!w_fin) begin
        if (seq_q[w_cur] > sqn_q) begin
          w_hit[w_cur] = 1'b1;
          if (w_cur == hd_q) w_fin = 1'b1;
          else               w_cur = w_cur - PW'(1);
        end else begin
          w_fin = 1'b1;
        end
      end
    end
    if (!w_fin && !(seq_q[w_cur] > sqn_q)) w_fin = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
      wp_q  <= '0;
      sqn_q <= '0;
      st_q  <= WK_IDLE;
    end else begin
      if (push) tl_q <= tl_q + PW'(1);
      if (pop)  hd_q <= hd_q + PW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (st_q == WK_IDLE) begin
        if (start) begin
          st_q  <= WK_RUN;
          wp_q  <= tl_q - PW'(1);
          sqn_q <= sq_num;
        end
      end else begin
        wp_q <= w_cur;
        if (w_fin) st_q <= WK_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= '0;
      sqd_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((st_q == WK_RUN) && w_hit[i]) begin
          rdy_q[i] <= 1'b1;
          sqd_q[i] <= 1'b1;
        end
        if (mark && (mark_slot == PW'(i))) rdy_q[i] <= 1'b1;
        if (push && (tl_q == PW'(i))) begin
          rdy_q[i] <= 1'b0;
          sqd_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) seq_q[tl_q] <= push_seq;
  end

  assign head_rdy  = (cnt_q != '0) && rdy_q[hd_q];
  assign head_seq  = seq_q[hd_q];
  assign head_sqd  = sqd_q[hd_q];
  assign tail_slot = tl_q;
  assign count     = cnt_q;
  assign walk_busy = (st_q == WK_RUN);

  // Assertion-only walk length counter
  logic [WCW-1:0] wcyc_q;
  always_ff @(posedge clk) begin
    if (!rst_n)               wcyc_q <= '0;
    else if (st_q == WK_RUN)  wcyc_q <= wcyc_q + WCW'(1);
    else                      wcyc_q <= '0;
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
  a_r3_pop_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> ((cnt_q != '0) && rdy_q[hd_q]));
  a_r6_empty_squash_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_req && (cnt_q == '0) && (st_q == WK_IDLE)) |=> (st_q == WK_IDLE));
  a_r8_walk_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WK_RUN) |-> (wcyc_q < WCW'(MAXW)));
  a_r9_walk_keeps_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == WK_RUN) && !push && !pop) |=> (cnt_q == $past(cnt_q)));
  a_r11_no_push_while_walking: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WK_RUN) |-> !push);

endmodule

// File: rtl/rob_occupancy.sv
`timescale 1ns/1ps
module rob_occupancy #(
  parameter int NTHR  = 2,
  parameter int DEPTH = 8,
  parameter int CAP   = 12,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int GW   = $clog2(NTHR * DEPTH + 1)
) (
  input  logic [CW-1:0] counts [NTHR],
  output logic [GW-1:0] total,
  output logic          has_room
);

  always_comb begin
    total = '0;
    for (int t = 0; t < NTHR; t++) total = total + GW'(counts[t]);
  end

  assign has_room = (total < GW'(CAP));

endmodule

// File: rtl/rob_commit_sel.sv
`timescale 1ns/1ps
module rob_commit_sel #(
  parameter int NTHR = 2,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [NTHR-1:0] head_rdy,
  input  logic [NTHR-1:0] busy,
  input  logic [NTHR-1:0] active,
  input  logic [TW-1:0]   ret_tid,
  input  logic            sq_valid,
  input  logic [TW-1:0]   sq_tid,
  output logic            can_commit,
  output logic            ret_ready
);

  assign can_commit = |(head_rdy & active);
  assign ret_ready  = head_rdy[ret_tid] && !busy[ret_tid] &&
                      !(sq_valid && (sq_tid == ret_tid));

endmodule

// File: rtl/rob_mt.sv
`timescale 1ns/1ps
module rob_mt #(
  parameter int NTHR     = 2,
  parameter int DEPTH    = 8,
  parameter int CAP      = 12,
  parameter int SEQ_W    = 16,
  parameter int SQ_WIDTH = 2,
  localparam int TW      = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int PW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [TW-1:0]    disp_tid,
  input  logic [SEQ_W-1:0] disp_seq,
  output logic [PW-1:0]    disp_slot,
  input  logic             cmpl_valid,
  input  logic [TW-1:0]    cmpl_tid,
  input  logic [PW-1:0]    cmpl_slot,
  input  logic             ret_valid,
  output logic             ret_ready,
  input  logic [TW-1:0]    ret_tid,
  output logic [SEQ_W-1:0] ret_seq,
  output logic             ret_squashed,
  input  logic             sq_valid,
  input  logic [TW-1:0]    sq_tid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [NTHR-1:0]  thr_active,
  output logic [NTHR-1:0]  head_ready,
  output logic             can_commit,
  output logic [NTHR-1:0]  sq_done
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int GW = $clog2(NTHR * DEPTH + 1);

  logic [CW-1:0]    cnt   [NTHR];
  logic [SEQ_W-1:0] hseq  [NTHR];
  logic [PW-1:0]    tslot [NTHR];
  logic [NTHR-1:0]  hsqd, busy, full, push, pop;
  logic [GW-1:0]    total;
  logic             has_room;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign full[t] = (cnt[t] == CW'(DEPTH));
    assign push[t] = disp_valid && disp_ready && (disp_tid == TW'(t));
    assign pop[t]  = ret_valid && ret_ready && (ret_tid == TW'(t));

    rob_thread_q #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_WIDTH(SQ_WIDTH)
    ) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[t]),
      .push_seq  (disp_seq),
      .tail_slot (tslot[t]),
      .pop       (pop[t]),
      .mark      (cmpl_valid && (cmpl_tid == TW'(t))),
      .mark_slot (cmpl_slot),
      .sq_req    (sq_valid && (sq_tid == TW'(t))),
      .sq_num    (sq_seq),
      .head_rdy  (head_ready[t]),
      .head_seq  (hseq[t]),
      .head_sqd  (hsqd[t]),
      .count     (cnt[t]),
      .walk_busy (busy[t])
    );

    assign sq_done[t] = !busy[t];
  end

  rob_occupancy #(.NTHR(NTHR), .DEPTH(DEPTH), .CAP(CAP)) u_occ (
    .counts   (cnt),
    .total    (total),
    .has_room (has_room)
  );

  rob_commit_sel #(.NTHR(NTHR)) u_sel (
    .head_rdy   (head_ready),
    .busy       (busy),
    .active     (thr_active),
    .ret_tid    (ret_tid),
    .sq_valid   (sq_valid),
    .sq_tid     (sq_tid),
    .can_commit (can_commit),
    .ret_ready  (ret_ready)
  );

  assign disp_ready = has_room && !full[disp_tid] && !busy[disp_tid] &&
                      !(sq_valid && (sq_tid == disp_tid));
  assign disp_slot    = tslot[disp_tid];
  assign ret_seq      = hseq[ret_tid];
  assign ret_squashed = hsqd[ret_tid];

  a_r2_global_cap: assert property (@(posedge clk) disable iff (!rst_n)
    total <= GW'(CAP));
  a_r10_stream_total: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|push) && !(|pop)) |=> (total == $past(total)));

endmodule

// File: tb/sim_rob_mt.sv
`timescale 1ns/1ps
module sim_rob_mt;
  localparam int NTHR = 2, DEPTH = 4, CAP = 6, SEQ_W = 8, SQW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_ready, cmpl_valid = 0, ret_valid = 0, ret_ready;
  logic [0:0] disp_tid = 0, cmpl_tid = 0, ret_tid = 0, sq_tid = 0;
  logic [SEQ_W-1:0] disp_seq = 0, ret_seq, sq_seq = 0;
  logic [1:0] disp_slot, cmpl_slot = 0;
  logic ret_squashed, sq_valid = 0, can_commit;
  logic [1:0] thr_active = 2'b11, head_ready, sq_done;

  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  rob_mt #(.NTHR(NTHR), .DEPTH(DEPTH), .CAP(CAP), .SEQ_W(SEQ_W), .SQ_WIDTH(SQW)) u0 (
    .clk, .rst_n, .disp_valid, .disp_ready, .disp_tid, .disp_seq, .disp_slot,
    .cmpl_valid, .cmpl_tid, .cmpl_slot, .ret_valid, .ret_ready, .ret_tid,
    .ret_seq, .ret_squashed, .sq_valid, .sq_tid, .sq_seq, .thr_active,
    .head_ready, .can_commit, .sq_done);

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic disp(input int t, input int s, output int slot);
    disp_valid = 1; disp_tid = t[0:0]; disp_seq = s[SEQ_W-1:0]; #1;
    check("R2 dispatch ready", disp_ready, 1);
    slot = disp_slot;
    tick(); disp_valid = 0;
  endtask

  task automatic cmpl(input int t, input int slot);
    cmpl_valid = 1; cmpl_tid = t[0:0]; cmpl_slot = slot[1:0];
    tick(); cmpl_valid = 0;
  endtask

  task automatic ret(input int t, input int s, input int sq, input string tag);
    ret_valid = 1; ret_tid = t[0:0]; #1;
    check({tag, " ret_ready"}, ret_ready, 1);
    check({tag, " ret_seq"}, ret_seq, s);
    check({tag, " ret_squashed"}, ret_squashed, sq);
    tick(); ret_valid = 0;
  endtask

  task automatic squash(input int t, input int s);
    sq_valid = 1; sq_tid = t[0:0]; sq_seq = s[SEQ_W-1:0];
    tick(); sq_valid = 0;
  endtask

  task automatic wait_done(input int t, output int c);
    c = 0;
    while (sq_done[t] == 1'b0 && c < 50) begin c++; tick(); end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int sl [8];
    int c, m, cexp;
    repeat (3) tick();
    rst_n = 1; tick();

    // R1 reset state
    check("R1 head_ready", head_ready, 0);
    check("R1 can_commit", can_commit, 0);
    check("R1 sq_done", sq_done, 3);
    disp_tid = 0; #1; check("R1 disp_ready t0", disp_ready, 1);
    disp_tid = 1; #1; check("R1 disp_ready t1", disp_ready, 1);
    tick();

    // R6 squash on empty thread
    squash(1, 0);
    check("R6 empty squash done", sq_done[1], 1);
    tick(); check("R6 empty squash done later", sq_done[1], 1);

    // R2 capacity: per-thread then global
    for (int i = 0; i < 4; i++) disp(0, 20 + i, sl[i]);
    disp_tid = 0; #1; check("R2 thread full", disp_ready, 0);
    disp(1, 30, sl[4]); disp(1, 31, sl[5]);
    disp_tid = 1; #1; check("R2 global CAP", disp_ready, 0);
    tick();

    // R3/R4 head not ready
    ret_tid = 0; #1;
    check("R3 not ready", ret_ready, 0);
    check("R4 head not ready", head_ready[0], 0);
    tick();
    cmpl(0, sl[0]);
    check("R4 head ready", head_ready[0], 1);
    // R5 active mask
    thr_active = 2'b10; #1; check("R5 inactive", can_commit, 0);
    thr_active = 2'b01; #1; check("R5 active", can_commit, 1);
    thr_active = 2'b11; #1; check("R5 both", can_commit, 1);
    tick();
    ret(0, 20, 0, "R3");

    // R10 dispatch and retire same thread same cycle
    cmpl(0, sl[1]);
    disp_valid = 1; disp_tid = 0; disp_seq = 24; ret_valid = 1; ret_tid = 0; #1;
    check("R10 disp_ready", disp_ready, 1);
    check("R10 ret_ready", ret_ready, 1);
    check("R10 ret_seq", ret_seq, 21);
    sl[6] = disp_slot;
    tick(); disp_valid = 0; ret_valid = 0;
    cmpl(0, sl[2]); cmpl(0, sl[3]); cmpl(0, sl[6]);
    ret(0, 22, 0, "R10"); ret(0, 23, 0, "R10"); ret(0, 24, 0, "R10");
    cmpl(1, sl[4]); cmpl(1, sl[5]);
    ret(1, 30, 0, "R3"); ret(1, 31, 0, "R3");
    check("R3 drained", head_ready, 0);

    // R11 squash during walk ignored
    for (int i = 0; i < 4; i++) disp(0, 10 + i, sl[i]);
    squash(0, 9);
    check("R11 walking", sq_done[0], 0);
    squash(0, 12);
    wait_done(0, c);
    for (int i = 0; i < 4; i++) ret(0, 10 + i, 1, "R11");

    // Sweep: R7 R8 R9 over thread, fill level and boundary
    for (int t = 0; t < 2; t++)
      for (int n = 1; n <= 4; n++)
        for (int s = 8; s <= 10 + n; s++) begin
          for (int i = 0; i < n; i++) disp(t, 10 + i, sl[i]);
          check("R4 fresh head", head_ready[t], 0);
          squash(t, s);
          m = 0;
          for (int i = 0; i < n; i++) if (10 + i > s) m++;
          cexp = (m == 0) ? 1 : (m + SQW - 1) / SQW;
          wait_done(t, c);
          check("R8 walk cycles", c, cexp);
          check("R7 head marked", head_ready[t], (10 > s) ? 1 : 0);
          for (int i = 0; i < n; i++) if (10 + i <= s) cmpl(t, sl[i]);
          for (int i = 0; i < n; i++) ret(t, 10 + i, (10 + i > s) ? 1 : 0, "R7 R9");
          check("R9 empty after drain", head_ready[t], 0);
        end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule